// File: doc/BRIEF.md
# Two-Level Latched Interrupt Aggregator

This block gathers level-sensitive interrupt requests from up to seventeen serial interrupt source lines and nine bus-cycle event lines into a sticky inner status word. Software qualifies that word with an inner mask and a global enable. The qualified inner result is copied into bit 11 of a read-only outer input word. An outer stage latches that input through its own mask into a second sticky status word. The single interrupt line leaving the block is high whenever any outer status bit is set.

Software reaches all registers over a simple 32-bit register bus with byte offsets. Only 4-byte accesses are accepted, and bit 31 of the data word is the most significant bit. Both status words are cleared by writing ones. The inner stage re-evaluates on every clock, so any write to a control, mask, status or polarity register takes effect at the next clock edge. A polarity word can be read and written but has no effect on behaviour.

Top module: `irq_cascade_agg`

## Requirements
- R1: After reset, every implemented register reads zero and `irq_out` is low.
- R2: While source line n (0 to 16) is high, inner status bit 31−n (offset 0x38) is set on each clock edge. A line going low does not clear its bit.
- R3: While `evt_lvl[8]` is high, inner status bit 10 is set. While `evt_lvl[k]` (k from 0 to 7) is high, inner status bit k is set. These bits are sticky in the same way as in R2.
- R4: A 4-byte write to 0x38 clears each inner status bit written as 1 and leaves bits written as 0 unchanged. A source or event held high in the same cycle keeps its bit set.
- R5: Bit 11 of the outer input register (0x5C) follows, one clock later, the inner result: control bit 31 (offset 0x30) AND (inner status AND inner mask at 0x34) being non-zero. All other bits of 0x5C read 0, and writes to 0x5C are ignored.
- R6: On each clock the outer status (0x50) accumulates outer input AND outer mask (0x54). A write to 0x50 clears the bits written as 1, and a bit that is still being accumulated stays set.
- R7: `irq_out` is high exactly when the outer status is non-zero. With the enable and both masks set, a source sampled high on clock edge k drives `irq_out` high after edge k+2.
- R8: The polarity register (0x58) reads back the last value written and has no effect on `irq_out` or on any status bit.
- R9: The control (0x30), inner mask (0x34) and outer mask (0x54) registers read back the full 32-bit value last written.
- R10: Reads of any offset other than 0x30, 0x34, 0x38, 0x50, 0x54, 0x58 and 0x5C return 0xFFFFFFFF. Writes to such offsets change no register.
- R11: For an access whose `reg_size` is not 4, `reg_err` is high, a write changes no register, and a read returns 0xFFFFFFFF.
- R12: Once an outer status bit is set, it stays set after the inner result falls, until software clears it. With the outer mask bit clear, the inner result sets no outer status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | NUM_SRC (17) | Serial interrupt source levels; line n maps to status bit 31−n |
| evt_lvl | input | 9 | Event levels: [8] reset event to bit 10, [7:0] bus-cycle errors and bus-master requests to bits 7..0 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the access |
| reg_size | input | 3 | Access size in bytes; only 4 is accepted |
| reg_wdata | input | 32 | Write data, bit 31 most significant |
| reg_rdata | output | 32 | Read data for `reg_addr`, valid in the same cycle |
| reg_err | output | 1 | High for an access whose size is not 4 bytes |
| irq_out | output | 1 | Aggregated interrupt line |

## Verification
Directed patterns single out individual requirements. One source line is asserted alone, which separates the bit mapping of the source lines from that of the event lines. The enable and each mask are toggled independently, which shows the enable gating apart from the masking in either stage. A write-to-clear is issued both while the source is held and after it is released, which distinguishes set priority from the clear itself. A long constrained-random run then mixes sparse source and event levels with random writes, including illegal sizes and unmapped offsets, against a cycle-level reference model. That run exposes ordering faults between clearing and accumulation in the two stages.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int DW        = 32;
    localparam int AW        = 8;
    localparam int SZW       = 3;
    localparam int EVT_W     = 9;
    localparam int ACC_BYTES = 4;

    // bit positions the software view depends on
    localparam int EN_BIT     = 31;
    localparam int LINK_BIT   = 11;
    localparam int LRST_BIT   = 10;
    localparam int LOW_EVT_W  = 8;

    localparam logic [AW-1:0] OFF_ICTRL = 8'h30;
    localparam logic [AW-1:0] OFF_IMASK = 8'h34;
    localparam logic [AW-1:0] OFF_ISTAT = 8'h38;
    localparam logic [AW-1:0] OFF_OSTAT = 8'h50;
    localparam logic [AW-1:0] OFF_OMASK = 8'h54;
    localparam logic [AW-1:0] OFF_OPOL  = 8'h58;
    localparam logic [AW-1:0] OFF_OIN   = 8'h5C;

    localparam logic [DW-1:0] ALL_ONES = '1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ICTRL,
        SEL_IMASK,
        SEL_ISTAT,
        SEL_OSTAT,
        SEL_OMASK,
        SEL_OPOL,
        SEL_OIN
    } reg_sel_e;

    typedef struct packed {
        logic            ictrl;
        logic            imask;
        logic            istat;
        logic            ostat;
        logic            omask;
        logic            opol;
        logic [DW-1:0]   data;
    } reg_wr_t;

    function automatic reg_sel_e decode_off(input logic [AW-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_ICTRL: s = SEL_ICTRL;
            OFF_IMASK: s = SEL_IMASK;
            OFF_ISTAT: s = SEL_ISTAT;
            OFF_OSTAT: s = SEL_OSTAT;
            OFF_OMASK: s = SEL_OMASK;
            OFF_OPOL:  s = SEL_OPOL;
            OFF_OIN:   s = SEL_OIN;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DW-1:0] evt_to_stat(input logic [EVT_W-1:0] e);
        logic [DW-1:0] v;
        v = '0;
        v[LRST_BIT] = e[EVT_W-1];
        v[LOW_EVT_W-1:0] = e[LOW_EVT_W-1:0];
        return v;
    endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_agg_pkg::*;
(
    input  logic            wr,
    input  logic            rd,
    input  logic [AW-1:0]   addr,
    input  logic [SZW-1:0]  size,
    input  logic [DW-1:0]   wdata,
    output reg_wr_t         wcmd,
    output reg_sel_e        sel,
    output logic            size_ok,
    output logic            err
);
    logic wr_ok;

    assign size_ok = (size == SZW'(ACC_BYTES));
    assign sel     = decode_off(addr);
    assign wr_ok   = wr && size_ok;
    assign err     = (wr || rd) && !size_ok;

    always_comb begin
        wcmd       = '0;
        wcmd.data  = wdata;
        wcmd.ictrl = wr_ok && (sel == SEL_ICTRL);
        wcmd.imask = wr_ok && (sel == SEL_IMASK);
        wcmd.istat = wr_ok && (sel == SEL_ISTAT);
        wcmd.ostat = wr_ok && (sel == SEL_OSTAT);
        wcmd.omask = wr_ok && (sel == SEL_OMASK);
        wcmd.opol  = wr_ok && (sel == SEL_OPOL);
    end
endmodule

// File: rtl/irq_inner_stage.sv
module irq_inner_stage
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 17
)(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_lvl,
    input  logic [EVT_W-1:0]    evt_lvl,
    input  reg_wr_t             wcmd,
    output logic [DW-1:0]       ctrl_q,
    output logic [DW-1:0]       mask_q,
    output logic [DW-1:0]       stat_q,
    output logic                agg_out
);
    logic [DW-1:0] src_vec;
    logic [DW-1:0] set_vec;
    logic [DW-1:0] clr_vec;

    // source line n lands on bit DW-1-n
    generate
        for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
            assign src_vec[DW-1-n] = src_lvl[n];
        end
        if (NUM_SRC < DW) begin : g_pad
            assign src_vec[DW-1-NUM_SRC:0] = '0;
        end
    endgenerate

    assign set_vec = src_vec | evt_to_stat(evt_lvl);
    assign clr_vec = wcmd.istat ? wcmd.data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mask_q <= '0;
            stat_q <= '0;
        end else begin
            if (wcmd.ictrl) ctrl_q <= wcmd.data;
            if (wcmd.imask) mask_q <= wcmd.data;
            // set has priority over a same-cycle clear
            stat_q <= (stat_q & ~clr_vec) | set_vec;
        end
    end

    assign agg_out = ctrl_q[EN_BIT] && ((stat_q & mask_q) != '0);
endmodule

// File: rtl/irq_outer_stage.sv
module irq_outer_stage
    import irq_agg_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           agg_in,
    input  reg_wr_t        wcmd,
    output logic [DW-1:0]  in_q,
    output logic [DW-1:0]  mask_q,
    output logic [DW-1:0]  pol_q,
    output logic [DW-1:0]  stat_q,
    output logic           irq
);
    logic [DW-1:0] in_next;
    logic [DW-1:0] clr_vec;

    always_comb begin
        in_next = '0;
        in_next[LINK_BIT] = agg_in;
    end

    assign clr_vec = wcmd.ostat ? wcmd.data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q   <= '0;
            mask_q <= '0;
            pol_q  <= '0;
            stat_q <= '0;
        end else begin
            in_q <= in_next;
            if (wcmd.omask) mask_q <= wcmd.data;
            if (wcmd.opol)  pol_q  <= wcmd.data;
            stat_q <= (stat_q & ~clr_vec) | (in_q & mask_q);
        end
    end

    assign irq = (stat_q != '0);
endmodule

// File: rtl/irq_cascade_agg.sv
module irq_cascade_agg
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 17
)(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_lvl,
    input  logic [EVT_W-1:0]    evt_lvl,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [AW-1:0]       reg_addr,
    input  logic [SZW-1:0]      reg_size,
    input  logic [DW-1:0]       reg_wdata,
    output logic [DW-1:0]       reg_rdata,
    output logic                reg_err,
    output logic                irq_out
);
    reg_wr_t       wcmd;
    reg_sel_e      rsel;
    logic          size_ok;
    logic [DW-1:0] ictrl_q, imask_q, istat_q;
    logic [DW-1:0] oin_q, omask_q, opol_q, ostat_q;
    logic          inner_agg;

    irq_reg_decode u_dec (
        .wr      (reg_wr),
        .rd      (reg_rd),
        .addr    (reg_addr),
        .size    (reg_size),
        .wdata   (reg_wdata),
        .wcmd    (wcmd),
        .sel     (rsel),
        .size_ok (size_ok),
        .err     (reg_err)
    );

    irq_inner_stage #(.NUM_SRC(NUM_SRC)) u_inner (
        .clk     (clk),
        .rst     (rst),
        .src_lvl (src_lvl),
        .evt_lvl (evt_lvl),
        .wcmd    (wcmd),
        .ctrl_q  (ictrl_q),
        .mask_q  (imask_q),
        .stat_q  (istat_q),
        .agg_out (inner_agg)
    );

    irq_outer_stage u_outer (
        .clk    (clk),
        .rst    (rst),
        .agg_in (inner_agg),
        .wcmd   (wcmd),
        .in_q   (oin_q),
        .mask_q (omask_q),
        .pol_q  (opol_q),
        .stat_q (ostat_q),
        .irq    (irq_out)
    );

    always_comb begin
        if (!size_ok) begin
            reg_rdata = ALL_ONES;
        end else begin
            case (rsel)
                SEL_ICTRL: reg_rdata = ictrl_q;
                SEL_IMASK: reg_rdata = imask_q;
                SEL_ISTAT: reg_rdata = istat_q;
                SEL_OSTAT: reg_rdata = ostat_q;
                SEL_OMASK: reg_rdata = omask_q;
                SEL_OPOL:  reg_rdata = opol_q;
                SEL_OIN:   reg_rdata = oin_q;
                default:   reg_rdata = ALL_ONES;
            endcase
        end
    end
endmodule

// File: rtl/irq_cascade_agg_chk.sv
module irq_cascade_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 17
)(
    input logic                clk,
    input logic                rst,
    input logic [NUM_SRC-1:0]  src_lvl,
    input logic                reg_wr,
    input logic [AW-1:0]       reg_addr,
    input logic [SZW-1:0]      reg_size,
    input logic                irq_out,
    input logic [DW-1:0]       ictrl,
    input logic [DW-1:0]       imask,
    input logic [DW-1:0]       istat,
    input logic [DW-1:0]       oin,
    input logic [DW-1:0]       omask,
    input logic [DW-1:0]       ostat
);
    logic good_wr;
    assign good_wr = reg_wr && (reg_size == SZW'(ACC_BYTES));

    // R2
    src0_sets_chk: assert property (@(posedge clk) disable iff (rst)
        src_lvl[0] |=> istat[DW-1]);

    // R4
    istat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !(good_wr && reg_addr == OFF_ISTAT) |=> ((istat & $past(istat)) == $past(istat)));

    // R5
    enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !ictrl[EN_BIT] |=> !oin[LINK_BIT]);

    // R7
    latch_to_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (oin[LINK_BIT] && omask[LINK_BIT]) |=> irq_out);

    // R12
    ostat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !(good_wr && reg_addr == OFF_OSTAT) |=> ((ostat & $past(ostat)) == $past(ostat)));

    // R11
    bad_size_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_size != SZW'(ACC_BYTES)) |=> ($stable(ictrl) && $stable(imask) && $stable(omask)));
endmodule

bind irq_cascade_agg irq_cascade_agg_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .src_lvl  (src_lvl),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_size (reg_size),
    .irq_out  (irq_out),
    .ictrl    (ictrl_q),
    .imask    (imask_q),
    .istat    (istat_q),
    .oin      (oin_q),
    .omask    (omask_q),
    .ostat    (ostat_q)
);

// File: tb/irq_cascade_agg_tb.sv
module irq_cascade_agg_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 17;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [NSRC-1:0] src_lvl = '0;
    logic [8:0]  evt_lvl = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [2:0]  reg_size = 3'd4;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_err;
    logic        irq_out;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_cascade_agg #(.NUM_SRC(NSRC)) u_dut (
        .clk(clk), .rst(rst), .src_lvl(src_lvl), .evt_lvl(evt_lvl),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_err(reg_err), .irq_out(irq_out)
    );

    // reference model built from the requirements
    logic [31:0] m_ctrl, m_imask, m_istat, m_oin, m_omask, m_opol, m_ostat;

    function automatic logic [31:0] set_bits(input logic [NSRC-1:0] s, input logic [8:0] e);
        logic [31:0] v = '0;
        for (int n = 0; n < NSRC; n++) if (s[n]) v[31-n] = 1'b1;
        if (e[8]) v[10] = 1'b1;
        v[7:0] = v[7:0] | e[7:0];
        return v;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [2:0] sz);
        if (sz != 3'd4) return 32'hFFFF_FFFF;
        case (a)
            8'h30: return m_ctrl;
            8'h34: return m_imask;
            8'h38: return m_istat;
            8'h50: return m_ostat;
            8'h54: return m_omask;
            8'h58: return m_opol;
            8'h5C: return m_oin;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    always @(posedge clk) begin
        logic ok;
        logic [31:0] iclr, oclr, nin;
        ok   = reg_wr && (reg_size == 3'd4);
        iclr = (ok && reg_addr == 8'h38) ? reg_wdata : 32'h0;
        oclr = (ok && reg_addr == 8'h50) ? reg_wdata : 32'h0;
        nin  = 32'h0;
        nin[11] = m_ctrl[31] && ((m_istat & m_imask) != 0);
        if (rst) begin
            m_ctrl <= 0; m_imask <= 0; m_istat <= 0; m_oin <= 0;
            m_omask <= 0; m_opol <= 0; m_ostat <= 0;
        end else begin
            if (ok && reg_addr == 8'h30) m_ctrl  <= reg_wdata;
            if (ok && reg_addr == 8'h34) m_imask <= reg_wdata;
            if (ok && reg_addr == 8'h54) m_omask <= reg_wdata;
            if (ok && reg_addr == 8'h58) m_opol  <= reg_wdata;
            m_istat <= (m_istat & ~iclr) | set_bits(src_lvl, evt_lvl);
            m_oin   <= nin;
            m_ostat <= (m_ostat & ~oclr) | (m_oin & m_omask);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_size = 3'd4; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a; reg_size = 3'd4;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; src_lvl = '0; evt_lvl = '0; reg_wr = 1'b0; reg_rd = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=%0d exp=%0d", total, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int unused_seed;
        unused_seed = $urandom(32'd20240611);

        do_reset();
        // R1 reset state
        chk("R1 irq", {31'b0, irq_out}, 32'h0);
        rd(8'h30, d); chk("R1 ctrl", d, 32'h0);
        rd(8'h38, d); chk("R1 istat", d, 32'h0);
        rd(8'h50, d); chk("R1 ostat", d, 32'h0);

        // R2 source 16 -> bit 15, sticky after release
        @(negedge clk); src_lvl = 17'h1_0000;
        @(negedge clk); src_lvl = '0;
        rd(8'h38, d); chk("R2 src16 sticky", d, 32'h0000_8000);
        // R4 clear with written ones only
        wr(8'h38, 32'h0000_0001);
        rd(8'h38, d); chk("R4 zero-bits kept", d, 32'h0000_8000);
        wr(8'h38, 32'h0000_8000);
        rd(8'h38, d); chk("R4 clear", d, 32'h0);

        // R3 event map
        @(negedge clk); evt_lvl = 9'h181;
        @(negedge clk); evt_lvl = '0;
        rd(8'h38, d); chk("R3 event bits", d, 32'h0000_0481);
        // R4 set wins while held
        @(negedge clk); src_lvl = 17'h0_0001;
        wr(8'h38, 32'hFFFF_FFFF);
        rd(8'h38, d); chk("R4 held source wins", d, 32'h8000_0000);
        @(negedge clk); src_lvl = '0;
        wr(8'h38, 32'hFFFF_FFFF);

        // R9 read back
        wr(8'h34, 32'hFFFF_FFFF);
        wr(8'h54, 32'h0000_0800);
        rd(8'h34, d); chk("R9 imask", d, 32'hFFFF_FFFF);
        rd(8'h54, d); chk("R9 omask", d, 32'h0000_0800);

        // R5 enable off: nothing propagates
        @(negedge clk); src_lvl = 17'h0_0008;
        @(negedge clk); src_lvl = '0;
        repeat (3) @(negedge clk);
        rd(8'h5C, d); chk("R5 gated by enable", d, 32'h0);
        chk("R5 irq low while disabled", {31'b0, irq_out}, 32'h0);

        // R7 latency with everything open
        wr(8'h38, 32'hFFFF_FFFF);
        wr(8'h30, 32'h8000_0000);
        rd(8'h30, d); chk("R9 ctrl", d, 32'h8000_0000);
        @(negedge clk); src_lvl = 17'h0_0008;   // sampled at edge k
        @(negedge clk); src_lvl = '0;
        chk("R7 k+0", {31'b0, irq_out}, 32'h0);
        rd(8'h5C, d); chk("R5 link bit", d, 32'h0000_0800);   // after k+1
        chk("R7 k+1", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        chk("R7 k+2", {31'b0, irq_out}, 32'h1);

        // R5 writes to input register ignored
        wr(8'h5C, 32'h0);
        rd(8'h5C, d); chk("R5 write ignored", d, 32'h0000_0800);

        // R12 outer stays latched after inner clears
        wr(8'h38, 32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
        rd(8'h5C, d); chk("R12 inner gone", d, 32'h0);
        chk("R12 outer sticky", {31'b0, irq_out}, 32'h1);
        wr(8'h50, 32'h0000_0800);
        @(negedge clk);
        chk("R6 outer clear", {31'b0, irq_out}, 32'h0);

        // R12 outer mask closed
        wr(8'h54, 32'h0);
        @(negedge clk); evt_lvl = 9'h100;
        @(negedge clk); evt_lvl = '0;
        repeat (3) @(negedge clk);
        rd(8'h5C, d); chk("R12 input set", d, 32'h0000_0800);
        rd(8'h50, d); chk("R12 masked outer", d, 32'h0);

        // R6 clear while still accumulating: re-set
        wr(8'h54, 32'h0000_0800);
        repeat (2) @(negedge clk);
        wr(8'h50, 32'h0000_0800);
        rd(8'h50, d); chk("R6 reaccumulate", d, 32'h0000_0800);

        // R8 polarity has no effect
        wr(8'h58, 32'hFFFF_FFFF);
        rd(8'h58, d); chk("R8 pol readback", d, 32'hFFFF_FFFF);
        chk("R8 irq unchanged", {31'b0, irq_out}, 32'h1);

        // R10 unmapped offsets
        rd(8'h40, d); chk("R10 unmapped read", d, 32'hFFFF_FFFF);
        wr(8'h3C, 32'h0);
        rd(8'h34, d); chk("R10 unmapped write", d, 32'hFFFF_FFFF);

        // R11 illegal size
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h34; reg_size = 3'd2; reg_wdata = 32'h0;
        #1 chk("R11 err flag", {31'b0, reg_err}, 32'h1);
        @(negedge clk); reg_wr = 1'b0; reg_size = 3'd4;
        rd(8'h34, d); chk("R11 write dropped", d, 32'hFFFF_FFFF);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 8'h30; reg_size = 3'd1;
        #1 chk("R11 read all ones", reg_rdata, 32'hFFFF_FFFF);
        reg_rd = 1'b0; reg_size = 3'd4;

        // constrained random run against the model
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            chk("R7 random irq", {31'b0, irq_out}, {31'b0, (m_ostat != 0)});
            reg_rd = 1'b1;
            reg_addr = 8'h30 + 8'(($urandom % 12) * 4);
            reg_size = ($urandom % 16 == 0) ? 3'd2 : 3'd4;
            #1 chk("R9 random read", reg_rdata, exp_read(reg_addr, reg_size));
            reg_rd = 1'b0;
            src_lvl = ($urandom % 8 == 0) ? NSRC'($urandom & $urandom & $urandom) : '0;
            evt_lvl = ($urandom % 10 == 0) ? 9'($urandom & $urandom) : '0;
            reg_wr = ($urandom % 4 == 0);
            reg_wdata = ($urandom % 3 == 0) ? 32'h8000_0800 : $urandom;
        end
        @(negedge clk);
        reg_wr = 1'b0; src_lvl = '0; evt_lvl = '0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule